// File: doc/BRIEF.md
# Second-LRU Victim Selection

This block chooses which way of one set of an N-way set-associative cache is returned for a lookup. It also keeps the recency order of every set. For each lookup the cache controller supplies a set index and three per-way flag vectors: valid, locked and hit. The block returns, in the same cycle, a way index and a flag that says whether that way hit.

When there is no hit and no invalid way, the default policy does not take the least-recently-used way. It takes the way just above it in the recency order, so the coldest line stays resident one replacement longer. The policy is a parameter of each instance. Structures that need plain LRU, such as translation buffers or outer cache levels, instantiate the same block with the LRU setting.

Recency is held inside the block as an age rank per way per set. Rank 0 is the most recent way and rank N-1 is the least recent. When the controller finishes an access it pulses `acc_valid` with the way it touched. The ranks of that set are updated on the next clock edge.

Top module: `nlru_victim_sel`

## Requirements
- R1: If any way's hit flag is set, the block returns that way and asserts `victim_hit`. `victim_hit` is low whenever no hit flag is set.
- R2: If no way hits and at least one way is invalid, the block returns the lowest-numbered invalid way.
- R3: In second-LRU mode, when no way hits, all ways are valid and two or more ways are unlocked, the block returns the unlocked way whose rank is second-highest among the unlocked ways.
- R4: When no way hits, all ways are valid and exactly one way is unlocked, the block returns that unlocked way.
- R5: In second-LRU mode, when all ways are valid and locked and none hits, the block returns the way with rank N-2.
- R6: In LRU mode, the block returns the highest-ranked unlocked way, or the way with rank N-1 when all ways are locked. Hits and invalid ways are handled as in R1 and R2.
- R7: An access to way W of a set makes W rank 0 on the next clock edge. Every other way of that set whose rank was below W's old rank gains one. All other ranks stay as they were.
- R8: While `acc_valid` is low, no rank changes, so a repeated lookup returns the same way.
- R9: An access to one set leaves the ranks of every other set unchanged.
- R10: After reset, way w of every set has rank w. With all ways valid and unlocked, a 4-way second-LRU instance therefore returns way 2, and an LRU instance returns way 3.
- R11: A 1-way instance always returns way 0, and its hit flag follows that way's hit input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx | input | SW | Set being looked up and updated |
| way_valid | input | WAYS | Per-way valid flags |
| way_locked | input | WAYS | Per-way locked flags |
| way_hit | input | WAYS | Per-way tag-match flags, at most one set |
| acc_valid | input | 1 | Access complete; update the recency of `set_idx` |
| acc_way | input | IW | Way touched by the completed access |
| victim_way | output | IW | Selected way |
| victim_hit | output | 1 | Selected way is a hit |

## Verification
A wrong rank in the stored order does not show at the ports until a lookup of that set falls through to the recency rules. That needs no hit, no invalid way, and a lock pattern that exposes the bad rank. The fault can therefore stay hidden for many cycles and then appear as the wrong `victim_way` on the first such lookup. The bench models the ranks independently and mixes full-valid and partially locked sets on every set. This keeps the time from a fault to a visible mismatch short. The checker also watches the ranks directly one cycle after each access.

// File: rtl/nlru_pkg.sv
package nlru_pkg;
    typedef enum logic {
        POL_LRU    = 1'b0,
        POL_SECOND = 1'b1
    } policy_e;

    function automatic int idx_bits(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/nlru_rank_store.sv
module nlru_rank_store #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    parameter int IW   = 2,
    parameter int SW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SW-1:0]            rd_set,
    input  logic                     upd_en,
    input  logic [SW-1:0]            upd_set,
    input  logic [IW-1:0]            upd_way,
    output logic [WAYS-1:0][IW-1:0]  rd_ranks
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][IW-1:0] rank;
    } rank_st_t;

    rank_st_t st_d, st_q;
    logic [IW-1:0] old_rank;

    always_comb begin
        st_d     = st_q;
        old_rank = st_q.rank[upd_set][upd_way];
        if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (upd_way == IW'(w)) begin
                    st_d.rank[upd_set][w] = '0;
                end else if (st_q.rank[upd_set][w] < old_rank) begin
                    st_d.rank[upd_set][w] = st_q.rank[upd_set][w] + IW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q.rank[s][w] <= IW'(w);
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ranks = st_q.rank[rd_set];
endmodule

// File: rtl/nlru_victim_pick.sv
module nlru_victim_pick
    import nlru_pkg::*;
#(
    parameter int      WAYS   = 4,
    parameter int      IW     = 2,
    parameter policy_e POLICY = POL_SECOND
) (
    input  logic [WAYS-1:0]          valid,
    input  logic [WAYS-1:0]          locked,
    input  logic [WAYS-1:0]          hit,
    input  logic [WAYS-1:0][IW-1:0]  ranks,
    output logic [IW-1:0]            victim,
    output logic                     is_hit
);
    generate
        if (WAYS == 1) begin : g_single
            logic unused_in;
            assign unused_in = valid[0] ^ locked[0] ^ (|ranks);
            assign victim    = '0;
            assign is_hit    = hit[0];
        end else begin : g_multi
            localparam int TGT_UNL = (POLICY == POL_SECOND) ? 1 : 0;
            localparam int TGT_ALL = (POLICY == POL_SECOND) ? WAYS - 2 : WAYS - 1;

            logic          hit_found, inv_found;
            logic [IW-1:0] hit_idx, inv_idx, only_unl, all_pick, unl_pick;
            int            unl_cnt;
            int            older [WAYS];

            always_comb begin
                hit_found = 1'b0;
                inv_found = 1'b0;
                hit_idx   = '0;
                inv_idx   = '0;
                only_unl  = '0;
                all_pick  = '0;
                unl_pick  = '0;
                unl_cnt   = 0;
                for (int w = WAYS - 1; w >= 0; w--) begin
                    if (hit[w]) begin
                        hit_found = 1'b1;
                        hit_idx   = IW'(w);
                    end
                    if (!valid[w]) begin
                        inv_found = 1'b1;
                        inv_idx   = IW'(w);
                    end
                end
                for (int w = 0; w < WAYS; w++) begin
                    older[w] = 0;
                    if (!locked[w]) begin
                        unl_cnt  = unl_cnt + 1;
                        only_unl = IW'(w);
                    end
                    if (ranks[w] == IW'(TGT_ALL)) begin
                        all_pick = IW'(w);
                    end
                    for (int v = 0; v < WAYS; v++) begin
                        if (v != w && !locked[v] && ranks[v] > ranks[w]) begin
                            older[w] = older[w] + 1;
                        end
                    end
                end
                for (int w = 0; w < WAYS; w++) begin
                    if (!locked[w] && older[w] == TGT_UNL) begin
                        unl_pick = IW'(w);
                    end
                end

                is_hit = 1'b0;
                if (hit_found) begin
                    victim = hit_idx;
                    is_hit = 1'b1;
                end else if (inv_found) begin
                    victim = inv_idx;
                end else if (unl_cnt == 0) begin
                    victim = all_pick;
                end else if (unl_cnt == 1) begin
                    victim = only_unl;
                end else begin
                    victim = unl_pick;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/nlru_victim_sel.sv
module nlru_victim_sel
    import nlru_pkg::*;
#(
    parameter int      WAYS   = 4,
    parameter int      SETS   = 16,
    parameter policy_e POLICY = POL_SECOND,
    localparam int     IW     = idx_bits(WAYS),
    localparam int     SW     = idx_bits(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    set_idx,
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAYS-1:0]  way_locked,
    input  logic [WAYS-1:0]  way_hit,
    input  logic             acc_valid,
    input  logic [IW-1:0]    acc_way,
    output logic [IW-1:0]    victim_way,
    output logic             victim_hit
);
    logic [WAYS-1:0][IW-1:0] set_ranks;

    nlru_rank_store #(
        .WAYS(WAYS), .SETS(SETS), .IW(IW), .SW(SW)
    ) i_ranks (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (set_idx),
        .upd_en   (acc_valid),
        .upd_set  (set_idx),
        .upd_way  (acc_way),
        .rd_ranks (set_ranks)
    );

    nlru_victim_pick #(
        .WAYS(WAYS), .IW(IW), .POLICY(POLICY)
    ) i_pick (
        .valid  (way_valid),
        .locked (way_locked),
        .hit    (way_hit),
        .ranks  (set_ranks),
        .victim (victim_way),
        .is_hit (victim_hit)
    );
endmodule

// File: rtl/nlru_victim_sel_chk.sv
module nlru_victim_sel_chk #(
    parameter int WAYS = 4,
    parameter int IW   = 2,
    parameter int SW   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [SW-1:0]            set_idx,
    input logic [WAYS-1:0]          way_valid,
    input logic [WAYS-1:0]          way_locked,
    input logic [WAYS-1:0]          way_hit,
    input logic                     acc_valid,
    input logic [IW-1:0]            acc_way,
    input logic [IW-1:0]            victim_way,
    input logic                     victim_hit,
    input logic [WAYS-1:0][IW-1:0]  set_ranks
);
    p_hit_way_r1: assert property (@(posedge clk) disable iff (!rst_n)
        victim_hit |-> way_hit[victim_way]);

    p_hit_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (way_hit == '0) |-> !victim_hit);

    p_invalid_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((way_hit == '0) && !(&way_valid)) |-> !way_valid[victim_way]);

    p_unlocked_pick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((way_hit == '0) && (&way_valid) && ($countones(~way_locked) >= 1))
        |-> !way_locked[victim_way]);

    p_touch_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid ##1 (set_idx == $past(set_idx)))
        |-> (set_ranks[$past(acc_way)] == '0));

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid ##1 (set_idx == $past(set_idx))) |-> $stable(set_ranks));
endmodule

bind nlru_victim_sel nlru_victim_sel_chk #(
    .WAYS(WAYS), .IW(IW), .SW(SW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (set_idx),
    .way_valid  (way_valid),
    .way_locked (way_locked),
    .way_hit    (way_hit),
    .acc_valid  (acc_valid),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .victim_hit (victim_hit),
    .set_ranks  (set_ranks)
);

// File: tb/test_nlru_victim_sel.sv
module test_nlru_victim_sel;
    import nlru_pkg::*;

    localparam int W = 4;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] set_idx = '0;
    logic [3:0] way_valid = '0, way_locked = '0, way_hit = '0;
    logic       acc_valid = 1'b0;
    logic [1:0] acc_way = '0;
    logic [1:0] vic_nx, vic_lru;
    logic       hit_nx, hit_lru;

    logic       w1_set = 1'b0, w1_valid = 1'b0, w1_locked = 1'b0, w1_hit = 1'b0;
    logic       w1_acc = 1'b0, w1_accway = 1'b0;
    logic       w1_vic, w1_vhit;

    int checks = 0, fails = 0;
    bit done = 0;
    int rk [2][S][W];

    always #5 clk = ~clk;

    nlru_victim_sel #(.WAYS(W), .SETS(S), .POLICY(POL_SECOND)) i_nlru_victim_sel (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .way_valid(way_valid),
        .way_locked(way_locked), .way_hit(way_hit), .acc_valid(acc_valid),
        .acc_way(acc_way), .victim_way(vic_nx), .victim_hit(hit_nx));

    nlru_victim_sel #(.WAYS(W), .SETS(S), .POLICY(POL_LRU)) i_lru_ref (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .way_valid(way_valid),
        .way_locked(way_locked), .way_hit(way_hit), .acc_valid(acc_valid),
        .acc_way(acc_way), .victim_way(vic_lru), .victim_hit(hit_lru));

    nlru_victim_sel #(.WAYS(1), .SETS(2), .POLICY(POL_SECOND)) i_one_way (
        .clk(clk), .rst_n(rst_n), .set_idx(w1_set), .way_valid(w1_valid),
        .way_locked(w1_locked), .way_hit(w1_hit), .acc_valid(w1_acc),
        .acc_way(w1_accway), .victim_way(w1_vic), .victim_hit(w1_vhit));

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // pol 0 = second-LRU, 1 = LRU. cat: 1 hit, 2 invalid, 3 multi-unlocked, 4 single, 5 all locked
    function automatic int ref_pick(input int pol, input int s, input bit [3:0] v,
                                    input bit [3:0] l, input bit [3:0] h,
                                    output bit eh, output int cat);
        int q[$];
        eh = 0;
        for (int w = 0; w < W; w++) if (h[w]) begin eh = 1; cat = 1; return w; end
        for (int w = 0; w < W; w++) if (!v[w]) begin cat = 2; return w; end
        for (int r = W - 1; r >= 0; r--)
            for (int w = 0; w < W; w++)
                if (rk[pol][s][w] == r && !l[w]) q.push_back(w);
        if (q.size() == 0) begin
            cat = 5;
            for (int w = 0; w < W; w++)
                if (rk[pol][s][w] == ((pol == 0) ? W - 2 : W - 1)) return w;
            return 0;
        end
        if (q.size() == 1) begin cat = 4; return q[0]; end
        cat = 3;
        return (pol == 0) ? q[1] : q[0];
    endfunction

    function automatic void ref_touch(input int pol, input int s, input int aw);
        int old = rk[pol][s][aw];
        for (int w = 0; w < W; w++) begin
            if (w == aw) rk[pol][s][w] = 0;
            else if (rk[pol][s][w] < old) rk[pol][s][w]++;
        end
    endfunction

    function automatic string cat_tag(input int cat, input int pol);
        if (cat == 1) return "R1";
        if (cat == 2) return "R2";
        if (pol == 1) return "R6";
        if (cat == 3) return "R3";
        if (cat == 4) return "R4";
        return "R5";
    endfunction

    task automatic step(input int s, input bit [3:0] v, input bit [3:0] l,
                        input bit [3:0] h, input bit acc, input int aw_sel,
                        input string note);
        bit e0h, e1h;
        int c0, c1, e0, e1, aw;
        @(negedge clk);
        set_idx = 2'(s); way_valid = v; way_locked = l; way_hit = h;
        w1_set = s[0]; w1_valid = v[0]; w1_locked = l[0]; w1_hit = h[0];
        w1_acc = acc; w1_accway = 1'b0;
        e0 = ref_pick(0, s, v, l, h, e0h, c0);
        e1 = ref_pick(1, s, v, l, h, e1h, c1);
        aw = (aw_sel < 0) ? e0 : aw_sel;
        acc_valid = acc; acc_way = 2'(aw);
        #2;
        check(int'(vic_nx), e0, (note != "") ? note : cat_tag(c0, 0));
        check(int'(hit_nx), int'(e0h), "R1");
        check(int'(vic_lru), e1, (note != "") ? note : cat_tag(c1, 1));
        check(int'(hit_lru), int'(e1h), "R1");
        check(int'(w1_vic), 0, "R11");
        check(int'(w1_vhit), int'(h[0]), "R11");
        @(posedge clk);
        if (acc) begin
            ref_touch(0, s, aw);
            ref_touch(1, s, aw);
        end
    endtask

    initial begin
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < S; s++)
                for (int w = 0; w < W; w++) rk[p][s][w] = w;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R10: reset order, way 2 for second-LRU and way 3 for LRU
        step(0, 4'hF, 4'h0, 4'h0, 0, 0, "R10");
        step(3, 4'hF, 4'h0, 4'h0, 0, 0, "R10");
        // R7: touch way 3 then way 0 of set 2
        step(2, 4'hF, 4'h0, 4'h0, 1, 3, "R7");
        step(2, 4'hF, 4'h0, 4'h0, 1, 0, "R7");
        step(2, 4'hF, 4'h0, 4'h0, 0, 0, "R7");
        // R8: idle lookups do not move the order
        step(2, 4'hF, 4'h0, 4'h0, 0, 0, "R8");
        step(2, 4'hF, 4'h0, 4'h0, 0, 0, "R8");
        // R9: churn set 1, then set 0 still at reset order
        step(1, 4'hF, 4'h0, 4'h0, 1, 2, "R9");
        step(1, 4'hF, 4'h0, 4'h0, 1, 1, "R9");
        step(0, 4'hF, 4'h0, 4'h0, 0, 0, "R9");
        // R5 / R4 / R2 / R1 directed corners
        step(2, 4'hF, 4'hF, 4'h0, 0, 0, "");
        step(2, 4'hF, 4'hB, 4'h0, 0, 0, "");
        step(2, 4'h5, 4'h0, 4'h0, 0, 0, "");
        step(2, 4'hF, 4'h0, 4'h4, 1, 2, "");

        for (int n = 0; n < 3000; n++) begin
            bit [3:0] v, l, h;
            int sel;
            v = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
            sel = $urandom % 5;
            case (sel)
                0: l = 4'h0;
                1: l = 4'hF;
                2: l = ~(4'b1 << ($urandom % 4));
                default: l = 4'($urandom);
            endcase
            h = 4'h0;
            if (($urandom % 4) == 0) begin
                int hw = $urandom % 4;
                if (v[hw]) h = 4'b1 << hw;
            end
            step($urandom % S, v, l, h, (($urandom % 3) != 0),
                 (($urandom % 2) == 0) ? -1 : int'($urandom % 4), "");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule